// File: doc/BRIEF.md
# Branch Record Filter Compactor

This unit holds a small stack of captured branch records. Each record has a source address, a target address and a classification word. After software or a neighbouring unit has loaded the records and named how many are valid, a single start pulse filters the stack against a requested-type mask. Records that fail the test are dropped. The survivors are moved down so that they sit contiguously from index 0 in their original relative order. The unit then reports the new count.

The classification word uses these bit positions. Bit 0 means the branch target lies in user space. Bit 1 means the target lies in kernel space. Bits 2 and up are branch categories such as call, return or conditional. The keep test is a subset test: every bit set in a record's type must also be set in the mask. Matching on a single bit is not enough.

Filtering runs in two passes. The first pass, one cycle per record, marks each rejected record by clearing its source address. The second pass, also one cycle per record, compacts the buffer with a read pointer and a write pointer. If nothing is marked, the second pass is skipped. If the mask is all ones, both passes are skipped.

Top module: `brfc_top`

## Requirements
- R1: When filtering is active, a record survives only if its type word is nonzero, every set bit of its type is also set in the mask, and its source address is nonzero.
- R2: A mask with all classification bits set skips filtering. `done` pulses on the clock edge that samples `start`, and the count and all records are left unchanged, including records with a zero type or a zero source.
- R3: After `done`, `rec_cnt` equals the number of survivors, and the survivors occupy indices 0 to `rec_cnt`-1 in their original relative order, with source, target and type intact.
- R4: If no record is dropped, the compaction pass is skipped. `done` rises `cnt` clock edges after the edge that sampled `start`, and the records are unchanged.
- R5: If at least one record is dropped, `done` rises 2·`cnt` clock edges after the edge that sampled `start`.
- R6: `busy` is high from the edge that samples `start` until the edge that raises `done`. `done` is a one-cycle pulse and is never high together with `busy`.
- R7: While `busy` is high, `start` and record loads are ignored, and `rec_cnt` does not change.
- R8: A start with `start_cnt` = 0 pulses `done` on the sampling edge and leaves `rec_cnt` at 0.
- R9: After reset, `busy`, `done` and `rec_cnt` are all 0.
- R10: The read port shows the record at `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one record (idle only) |
| ld_idx | input | IDX_W | Record index to write |
| ld_from | input | 32 | Source address to write |
| ld_to | input | 32 | Target address to write |
| ld_type | input | 12 | Classification word to write |
| start | input | 1 | Begin a filter run (idle only) |
| start_cnt | input | CNT_W | Number of valid records, at most DEPTH |
| sel_mask | input | 12 | Requested-type mask |
| rd_idx | input | IDX_W | Read index |
| rd_from | output | 32 | Source address at `rd_idx` |
| rd_to | output | 32 | Target address at `rd_idx` |
| rd_type | output | 12 | Classification word at `rd_idx` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rec_cnt | output | CNT_W | Valid record count |

## Verification
The bound checker watches every cycle for these properties:
- the single-cycle `done` pulse and its exclusion from `busy`;
- the stability of the count during a run;
- the immediate completion for an all-ones mask and for an empty stack;
- the bound on the count.

Only the bench scenarios can show which records survive the subset test, their order after compaction, and the exact 0, `cnt` or 2·`cnt` latency. The bench shows these by comparing the outputs with a queue-based model on every clock and then reading back the whole surviving stack.

// File: rtl/brfc_pkg.sv
package brfc_pkg;
    localparam int ADDR_W = 32;
    localparam int TYPE_W = 12;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TYPE_W-1:0] btype_t;

    typedef struct packed {
        addr_t  src;
        addr_t  dst;
        btype_t kind;
    } brec_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MARK = 2'd1,
        PH_PACK = 2'd2
    } phase_e;

    // all classification bits requested: no filtering needed
    function automatic logic mask_is_full(btype_t m);
        return &m;
    endfunction

    // subset test: every bit of the record type must be requested
    function automatic logic rec_passes(btype_t m, brec_t r);
        return (r.kind != '0) && ((m & r.kind) == r.kind) && (r.src != '0);
    endfunction
endpackage

// File: rtl/brfc_keep.sv
module brfc_keep
    import brfc_pkg::*;
(
    input  btype_t mask,
    input  brec_t  rec,
    output logic   keep
);
    always_comb keep = rec_passes(mask, rec);
endmodule

// File: rtl/brfc_store.sv
module brfc_store
    import brfc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  brec_t            ld_rec,
    input  logic             clr_en,
    input  logic             mv_en,
    input  logic [IDX_W-1:0] scan_idx,
    input  logic [IDX_W-1:0] mv_dst,
    output brec_t            scan_rec,
    input  logic [IDX_W-1:0] rd_idx,
    output brec_t            rd_rec
);
    brec_t mem [DEPTH];

    always_comb begin
        scan_rec = mem[scan_idx];
        rd_rec   = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_idx] <= ld_rec;
        end else if (clr_en) begin
            mem[scan_idx].src <= '0;
        end else if (mv_en) begin
            mem[mv_dst] <= mem[scan_idx];
        end
    end
endmodule

// File: rtl/brfc_ctrl.sv
module brfc_ctrl
    import brfc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  btype_t           sel_mask,
    input  brec_t            scan_rec,
    input  logic             keep,
    output btype_t           mask_q,
    output logic [IDX_W-1:0] scan_idx,
    output logic [IDX_W-1:0] mv_dst,
    output logic             clr_en,
    output logic             mv_en,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] rec_cnt
);
    phase_e           ph;
    logic [CNT_W-1:0] rp;
    logic [CNT_W-1:0] wp;
    logic             marked;
    logic             last;
    logic             live;

    always_comb begin
        last     = (rp == rec_cnt - CNT_W'(1));
        live     = (scan_rec.src != '0);
        scan_idx = rp[IDX_W-1:0];
        mv_dst   = wp[IDX_W-1:0];
        clr_en   = (ph == PH_MARK) && !keep;
        mv_en    = (ph == PH_PACK) && live;
        busy     = (ph != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            rp      <= '0;
            wp      <= '0;
            marked  <= 1'b0;
            mask_q  <= '0;
            rec_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        rec_cnt <= start_cnt;
                        mask_q  <= sel_mask;
                        rp      <= '0;
                        wp      <= '0;
                        marked  <= 1'b0;
                        if (start_cnt == '0 || mask_is_full(sel_mask)) begin
                            done <= 1'b1;
                        end else begin
                            ph <= PH_MARK;
                        end
                    end
                end
                PH_MARK: begin
                    if (!keep) marked <= 1'b1;
                    if (last) begin
                        rp <= '0;
                        if (marked || !keep) begin
                            ph <= PH_PACK;
                        end else begin
                            ph   <= PH_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        rp <= rp + CNT_W'(1);
                    end
                end
                PH_PACK: begin
                    if (live) wp <= wp + CNT_W'(1);
                    if (last) begin
                        rec_cnt <= wp + CNT_W'(live);
                        ph      <= PH_IDLE;
                        done    <= 1'b1;
                    end else begin
                        rp <= rp + CNT_W'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/brfc_top.sv
module brfc_top
    import brfc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ADDR_W-1:0] ld_from,
    input  logic [ADDR_W-1:0] ld_to,
    input  logic [TYPE_W-1:0] ld_type,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [TYPE_W-1:0] sel_mask,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to,
    output logic [TYPE_W-1:0] rd_type,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  rec_cnt
);
    brec_t            ld_rec;
    brec_t            scan_rec;
    brec_t            rd_rec;
    btype_t           mask_q;
    logic [IDX_W-1:0] scan_idx;
    logic [IDX_W-1:0] mv_dst;
    logic             clr_en;
    logic             mv_en;
    logic             keep;
    logic             ld_ok;

    always_comb begin
        ld_rec  = '{src: ld_from, dst: ld_to, kind: ld_type};
        ld_ok   = ld_en && !busy;
        rd_from = rd_rec.src;
        rd_to   = rd_rec.dst;
        rd_type = rd_rec.kind;
    end

    brfc_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .ld_en    (ld_ok),
        .ld_idx   (ld_idx),
        .ld_rec   (ld_rec),
        .clr_en   (clr_en),
        .mv_en    (mv_en),
        .scan_idx (scan_idx),
        .mv_dst   (mv_dst),
        .scan_rec (scan_rec),
        .rd_idx   (rd_idx),
        .rd_rec   (rd_rec)
    );

    brfc_keep u_keep (
        .mask (mask_q),
        .rec  (scan_rec),
        .keep (keep)
    );

    brfc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_cnt (start_cnt),
        .sel_mask  (sel_mask),
        .scan_rec  (scan_rec),
        .keep      (keep),
        .mask_q    (mask_q),
        .scan_idx  (scan_idx),
        .mv_dst    (mv_dst),
        .clr_en    (clr_en),
        .mv_en     (mv_en),
        .busy      (busy),
        .done      (done),
        .rec_cnt   (rec_cnt)
    );
endmodule

// File: rtl/brfc_chk.sv
module brfc_chk
    import brfc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] start_cnt,
    input btype_t           sel_mask,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] rec_cnt
);
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_full_skip_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (&sel_mask)) |=> (done && rec_cnt == $past(start_cnt)));

    p_empty_run_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && start_cnt == '0) |=> (done && rec_cnt == '0));

    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rec_cnt));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        rec_cnt <= CNT_W'(DEPTH));
endmodule

bind brfc_top brfc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_cnt (start_cnt),
    .sel_mask  (sel_mask),
    .busy      (busy),
    .done      (done),
    .rec_cnt   (rec_cnt)
);

// File: tb/sim_brfc_top.sv
module sim_brfc_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int IDX_W = 4;
    localparam int CNT_W = 5;
    localparam int AW = 32;
    localparam int TW = 12;

    localparam logic [TW-1:0] T_U    = 12'h001;
    localparam logic [TW-1:0] T_K    = 12'h002;
    localparam logic [TW-1:0] T_CALL = 12'h004;
    localparam logic [TW-1:0] T_RET  = 12'h008;
    localparam logic [TW-1:0] T_JCC  = 12'h100;
    localparam logic [TW-1:0] T_JMP  = 12'h200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_en = 1'b0;
    logic [IDX_W-1:0] ld_idx = '0;
    logic [AW-1:0] ld_from = '0;
    logic [AW-1:0] ld_to = '0;
    logic [TW-1:0] ld_type = '0;
    logic start = 1'b0;
    logic [CNT_W-1:0] start_cnt = '0;
    logic [TW-1:0] sel_mask = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [AW-1:0] rd_from;
    logic [AW-1:0] rd_to;
    logic [TW-1:0] rd_type;
    logic busy;
    logic done;
    logic [CNT_W-1:0] rec_cnt;

    brfc_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_from(ld_from), .ld_to(ld_to), .ld_type(ld_type),
        .start(start), .start_cnt(start_cnt), .sel_mask(sel_mask),
        .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to), .rd_type(rd_type),
        .busy(busy), .done(done), .rec_cnt(rec_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] m_from [DEPTH];
    logic [AW-1:0] m_to   [DEPTH];
    logic [TW-1:0] m_type [DEPTH];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(int i, logic [AW-1:0] f, logic [AW-1:0] t, logic [TW-1:0] ty);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = IDX_W'(i); ld_from = f; ld_to = t; ld_type = ty;
        @(negedge clk);
        ld_en = 1'b0;
        m_from[i] = f; m_to[i] = t; m_type[i] = ty;
    endtask

    // queue-based reference model, compared on every clock of the run
    task automatic run(logic [TW-1:0] mask, int cnt, bit poke, string tag);
        int keep_q[$];
        bit full;
        int lat;
        logic [AW-1:0] nf [DEPTH];
        logic [AW-1:0] nt [DEPTH];
        logic [TW-1:0] ny [DEPTH];
        full = &mask;
        for (int i = 0; i < cnt; i++) begin
            if (full || (m_type[i] != '0 && (mask & m_type[i]) == m_type[i] && m_from[i] != '0))
                keep_q.push_back(i);
        end
        if (cnt == 0 || full) lat = 0;
        else if (keep_q.size() == cnt) lat = cnt;
        else lat = 2 * cnt;
        @(negedge clk);
        start = 1'b1; sel_mask = mask; start_cnt = CNT_W'(cnt);
        for (int k = 0; k <= lat + 1; k++) begin
            @(negedge clk);
            start = (poke && k == 0) ? 1'b1 : 1'b0;
            if (poke && k == 0) start_cnt = CNT_W'(1);
            if (poke && k == 1) begin
                ld_en = 1'b1; ld_idx = '0; ld_from = 32'hDEAD_0000;
                ld_to = 32'hDEAD_0001; ld_type = T_U;
            end
            if (k == 2) ld_en = 1'b0;
            chk({tag, " R6 busy"}, 64'(busy), 64'(k < lat));
            chk({tag, " R4 R5 done timing"}, 64'(done), 64'(k == lat));
        end
        ld_en = 1'b0;
        foreach (keep_q[j]) begin
            nf[j] = m_from[keep_q[j]]; nt[j] = m_to[keep_q[j]]; ny[j] = m_type[keep_q[j]];
        end
        foreach (keep_q[j]) begin
            m_from[j] = nf[j]; m_to[j] = nt[j]; m_type[j] = ny[j];
        end
        chk({tag, " R3 count"}, 64'(rec_cnt), 64'(keep_q.size()));
        for (int j = 0; j < keep_q.size(); j++) begin
            rd_idx = IDX_W'(j);
            #1;
            chk({tag, " R3 R10 from"}, 64'(rd_from), 64'(m_from[j]));
            chk({tag, " R3 R10 to"},   64'(rd_to),   64'(m_to[j]));
            chk({tag, " R1 R3 type"},  64'(rd_type), 64'(m_type[j]));
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 busy", 64'(busy), 64'd0);
        chk("R9 done", 64'(done), 64'd0);
        chk("R9 count", 64'(rec_cnt), 64'd0);

        // R1 R5: mixed types, subset test, some dropped
        load(0, 32'h1000, 32'h2000, T_U | T_CALL);
        load(1, 32'h1004, 32'h2004, T_U | T_JCC);
        load(2, 32'h1008, 32'h2008, T_K | T_CALL);
        load(3, 32'h100C, 32'h200C, T_U | T_RET);
        load(4, 32'h1010, 32'h2010, 12'h000);
        load(5, 32'h1014, 32'h2014, T_U | T_CALL);
        load(6, 32'h0000, 32'h2018, T_U | T_CALL);
        load(7, 32'h101C, 32'h201C, T_U | T_JMP);
        run(T_U | T_CALL | T_RET, 8, 1'b0, "mixed");

        // R1: single matching bit is not enough
        load(0, 32'h3000, 32'h4000, T_U | T_JCC);
        load(1, 32'h3004, 32'h4004, T_U);
        run(T_U, 2, 1'b0, "subset");

        // R4: nothing dropped, compaction skipped
        for (int i = 0; i < 5; i++) load(i, 32'h5000 + 32'(i), 32'h6000 + 32'(i), T_U | T_CALL);
        run(T_U | T_K | T_CALL, 5, 1'b0, "nodrop");

        // R2: full mask keeps zero type and zero source
        load(0, 32'h7000, 32'h8000, 12'h000);
        load(1, 32'h0000, 32'h8004, T_K | T_JMP);
        load(2, 32'h7008, 32'h8008, T_U | T_RET);
        run(12'hFFF, 3, 1'b0, "full R2");

        // R8: empty stack
        run(T_U, 0, 1'b0, "empty R8");

        // R7: full depth, start and load attempted while busy
        for (int i = 0; i < DEPTH; i++)
            load(i, 32'h9000 + 32'(i), 32'hA000 + 32'(i), (i % 3 == 0) ? (T_K | T_JCC) : (T_U | T_JCC));
        run(T_U | T_JCC, DEPTH, 1'b1, "busy R7");

        // R1 R3: every record dropped
        load(0, 32'hB000, 32'hC000, T_K);
        load(1, 32'hB004, 32'hC004, T_K | T_RET);
        run(T_U | T_RET, 2, 1'b0, "alldrop");

        summary();
        $finish;
    end
endmodule